// File: doc/BRIEF.md
# Dual Sync Mark Finder with NRZ Output Gating

This block sits behind the run-length decoder of a disk read channel. It sees one decoded byte every nine code clocks, and a strobe marks each byte. While read gate is high, the block hunts for a sync mark. Two fixed byte values count as a mark: a leading mark `8'h1F` and a trailing mark `8'h69`. In the two-mark sector format, the two marks are separated by one training byte `8'h93`.

The block reports the mark on an active-low detect output. Until then it holds the byte-wide output at all zeros. If the trailing mark is found first, detection happens on the next clock. If the leading mark is found first, detection is delayed by two byte times, counted in code clocks. In both cases the first nonzero byte seen downstream is `8'h69`, and the byte after it is the first user byte.

Once detection has happened, the block ignores further marks until read gate drops. When read gate drops, the detect output is released and the output-enable is removed. The output-enable stands in for a tri-state pad.

A defect-scan mode replaces pattern matching with a sector-field strobe. In that mode the most significant output bit flags every byte that is not all zeros.

Top module: `sync_mark_finder`

## Requirements
- R1: While reset is asserted and until read gate first rises, `sync_n` is 1, `nrz_oe` is 0 and `nrz_out` is 8'h00.
- R2: A strobed byte 8'h1F while hunting makes `sync_n` go low exactly 18 clock edges after the edge that captured it. On that same edge `nrz_out` becomes 8'h69.
- R3: A strobed byte 8'h69 while hunting makes `sync_n` low and `nrz_out` equal to 8'h69 from the capturing edge onward.
- R4: After detection, each strobed byte appears on `nrz_out` at the capturing edge and is held until the next strobe.
- R5: While read gate is high and no mark has been detected, `nrz_oe` is 1 and `nrz_out` is 8'h00, whatever non-mark bytes are strobed.
- R6: One edge after read gate is sampled low, `sync_n` is 1, `nrz_oe` is 0 and `nrz_out` is 8'h00.
- R7: After detection, strobed 8'h1F or 8'h69 bytes pass through as data. `sync_n` stays low and no delayed 8'h69 is inserted.
- R8: During the 18-clock delay that follows 8'h1F, a strobed 8'h69 neither shortens the delay nor reaches `nrz_out`.
- R9: With `scan_en` high, mark bytes cause no detection. A `sfc_hit` pulse while hunting makes `sync_n` low with `nrz_out` 8'h00 at the next edge.
- R10: After detection in scan mode, each strobed byte yields `nrz_out` = {byte != 0, 7'b0}.
- R11: The first clock edge with read gate high after a low period only enables the output. A strobe on that edge is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | code clock |
| rst_n | input | 1 | asynchronous active-low reset, released synchronously |
| rd_gate | input | 1 | read gate, high while a sector is read |
| byte_stb | input | 1 | marks a valid decoded byte on `byte_in` |
| byte_in | input | 8 | decoded byte |
| scan_en | input | 1 | selects defect-scan mode |
| sfc_hit | input | 1 | sector-field strobe used for detection in scan mode |
| sync_n | output | 1 | active-low sync detected |
| nrz_out | output | 8 | NRZ data output |
| nrz_oe | output | 1 | output enable for `nrz_out` |

## Verification
Some properties are checked on every cycle:
- Output-enable release after read gate drops.
- All-zero output while hunting.
- Immediate lock on the trailing mark.
- Detect staying low until the gate falls.
- The delay counter staying inside its range.

Other behaviours only show up in the bench's scenarios:
- The exact 18-edge delay after the leading mark.
- Immunity to a trailing mark that arrives inside that delay.
- Pass-through of user bytes and of repeated marks.
- The scan-mode defect flag.
- An exhaustive sweep of all 256 first-byte values.

// File: rtl/smf_pkg.sv
package smf_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] MARK_LEAD  = 8'h1F;
  localparam logic [BYTE_W-1:0] MARK_TRAIL = 8'h69;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HUNT = 2'd1,
    ST_WAIT = 2'd2,
    ST_LOCK = 2'd3
  } smf_state_t;
endpackage

// File: rtl/smf_match.sv
module smf_match #(
  parameter int W    = 8,
  parameter int NPAT = 2,
  parameter logic [NPAT-1:0][W-1:0] PATS = '0
) (
  input  logic [W-1:0]    data_i,
  output logic [NPAT-1:0] hit_o
);
  for (genvar g = 0; g < NPAT; g++) begin : g_cmp
    assign hit_o[g] = (data_i == PATS[g]);
  end
endmodule

// File: rtl/smf_delay.sv
module smf_delay #(
  parameter int DELAY = 18
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic clr_i,
  output logic done_o
);
  localparam int CW = $clog2(DELAY + 1);
  localparam logic [CW-1:0] START = CW'(DELAY - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d;
  logic          cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    cnt_en = 1'b0;
    if (clr_i) begin
      cnt_d  = '0;
      busy_d = 1'b0;
      cnt_en = 1'b1;
    end else if (load_i) begin
      cnt_d  = START;
      busy_d = 1'b1;
      cnt_en = 1'b1;
    end else if (busy_q) begin
      cnt_en = 1'b1;
      if (cnt_q == '0) busy_d = 1'b0;
      else             cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assign done_o = busy_q && (cnt_q == '0);

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= START) else $error("counter out of range"); // R2
  AST_DONE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !load_i |=> !done_o) else $error("done repeated"); // R2
endmodule

// File: rtl/sync_mark_finder.sv
module sync_mark_finder #(
  parameter int BYTE_CLKS = 9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_gate,
  input  logic       byte_stb,
  input  logic [7:0] byte_in,
  input  logic       scan_en,
  input  logic       sfc_hit,
  output logic       sync_n,
  output logic [7:0] nrz_out,
  output logic       nrz_oe
);
  import smf_pkg::*;

  localparam int DELAY = 2 * BYTE_CLKS;

  logic rst_s1, rst_ln;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_ln <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_ln <= rst_s1;
    end
  end

  logic [1:0] hit;
  smf_match #(
    .W(BYTE_W), .NPAT(2), .PATS({MARK_TRAIL, MARK_LEAD})
  ) i_match (
    .data_i(byte_in),
    .hit_o (hit)
  );

  logic dly_load, dly_done;
  smf_delay #(.DELAY(DELAY)) i_delay (
    .clk   (clk),
    .rst_n (rst_ln),
    .load_i(dly_load),
    .clr_i (!rd_gate),
    .done_o(dly_done)
  );

  smf_state_t       st_q, st_d;
  logic             sync_q, sync_d;
  logic             oe_q, oe_d;
  logic [BYTE_W-1:0] dat_q, dat_d;

  always_comb begin
    st_d     = st_q;
    sync_d   = sync_q;
    oe_d     = oe_q;
    dat_d    = dat_q;
    dly_load = 1'b0;
    if (!rd_gate) begin
      st_d   = ST_IDLE;
      sync_d = 1'b1;
      oe_d   = 1'b0;
      dat_d  = '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          st_d  = ST_HUNT;
          oe_d  = 1'b1;
          dat_d = '0;
        end
        ST_HUNT: begin
          if (scan_en) begin
            if (sfc_hit) begin
              st_d   = ST_LOCK;
              sync_d = 1'b0;
              dat_d  = '0;
            end
          end else if (byte_stb) begin
            if (hit[1]) begin
              st_d   = ST_LOCK;
              sync_d = 1'b0;
              dat_d  = MARK_TRAIL;
            end else if (hit[0]) begin
              st_d     = ST_WAIT;
              dly_load = 1'b1;
            end
          end
        end
        ST_WAIT: begin
          if (dly_done) begin
            st_d   = ST_LOCK;
            sync_d = 1'b0;
            dat_d  = MARK_TRAIL;
          end
        end
        ST_LOCK: begin
          if (byte_stb)
            dat_d = scan_en ? {(byte_in != '0), {(BYTE_W-1){1'b0}}} : byte_in;
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ln) begin
    if (!rst_ln) begin
      st_q   <= ST_IDLE;
      sync_q <= 1'b1;
      oe_q   <= 1'b0;
      dat_q  <= '0;
    end else begin
      st_q   <= st_d;
      sync_q <= sync_d;
      oe_q   <= oe_d;
      dat_q  <= dat_d;
    end
  end

  assign sync_n  = sync_q;
  assign nrz_oe  = oe_q;
  assign nrz_out = dat_q;

  AST_GATE_RELEASE: assert property (@(posedge clk) disable iff (!rst_ln)
    !rd_gate |=> (!nrz_oe && sync_n && nrz_out == '0)) else $error("gate release"); // R6
  AST_HUNT_ZERO: assert property (@(posedge clk) disable iff (!rst_ln)
    sync_n |-> nrz_out == '0) else $error("data before detect"); // R5
  AST_TRAIL_LOCK: assert property (@(posedge clk) disable iff (!rst_ln)
    (rd_gate && st_q == ST_HUNT && !scan_en && byte_stb && byte_in == MARK_TRAIL)
    |=> (!sync_n && nrz_out == MARK_TRAIL)) else $error("trail lock"); // R3
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_ln)
    (rd_gate && !sync_n) |=> !sync_n) else $error("detect dropped"); // R7
  AST_SCAN_LOCK: assert property (@(posedge clk) disable iff (!rst_ln)
    (rd_gate && st_q == ST_HUNT && scan_en && sfc_hit) |=> !sync_n) else $error("scan lock"); // R9
endmodule

// File: tb/test_sync_mark_finder.sv
module test_sync_mark_finder;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       rd_gate, byte_stb, scan_en, sfc_hit;
  logic [7:0] byte_in;
  logic       sync_n, nrz_oe;
  logic [7:0] nrz_out;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  sync_mark_finder i_sync_mark_finder (
    .clk(clk), .rst_n(rst_n), .rd_gate(rd_gate), .byte_stb(byte_stb),
    .byte_in(byte_in), .scan_en(scan_en), .sfc_hit(sfc_hit),
    .sync_n(sync_n), .nrz_out(nrz_out), .nrz_oe(nrz_oe)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // drive one strobed byte; returns after the capturing edge, at a negedge
  task automatic send(input logic [7:0] v);
    byte_stb = 1'b1; byte_in = v;
    @(posedge clk); @(negedge clk);
    byte_stb = 1'b0; byte_in = 8'h00;
  endtask

  task automatic regate();
    rd_gate = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R6 sync_n", {7'b0, sync_n}, 8'h01);
    chk("R6 oe", {7'b0, nrz_oe}, 8'h00);
    chk("R6 data", nrz_out, 8'h00);
    rd_gate = 1'b1;
    byte_stb = 1'b1; byte_in = 8'h69;
    @(posedge clk); @(negedge clk);
    byte_stb = 1'b0; byte_in = 8'h00;
    chk("R11 strobe ignored on enable edge", {7'b0, sync_n}, 8'h01);
    chk("R5 oe", {7'b0, nrz_oe}, 8'h01);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; rd_gate = 1'b0; byte_stb = 1'b0; byte_in = 8'h00;
    scan_en = 1'b0; sfc_hit = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 sync_n", {7'b0, sync_n}, 8'h01);
    chk("R1 oe", {7'b0, nrz_oe}, 8'h00);
    chk("R1 data", nrz_out, 8'h00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 after release", {7'b0, sync_n, nrz_oe}, 8'h02);

    // R5 / R3: sweep every possible first byte
    for (int v = 0; v < 256; v++) begin
      regate();
      send(8'(v));
      if (v == 8'h69) begin
        chk("R3 sync_n", {7'b0, sync_n}, 8'h00);
        chk("R3 data", nrz_out, 8'h69);
      end else begin
        chk("R5 sync_n", {7'b0, sync_n}, 8'h01);
        chk("R5 data", nrz_out, 8'h00);
      end
    end

    // R2 / R8: leading mark, training byte, trailing mark inside the delay
    regate();
    send(8'h1F);
    for (int k = 1; k <= 18; k++) begin
      if (k == 9 || k == 18) byte_stb = 1'b1;
      byte_in = (k == 9) ? 8'h93 : (k == 18) ? 8'h69 : 8'h00;
      if (k == 5) begin byte_stb = 1'b1; byte_in = 8'h69; end
      @(posedge clk); @(negedge clk);
      byte_stb = 1'b0; byte_in = 8'h00;
      if (k < 18) begin
        chk("R8 no early detect", {7'b0, sync_n}, 8'h01);
        chk("R8 data held zero", nrz_out, 8'h00);
      end else begin
        chk("R2 detect at 18", {7'b0, sync_n}, 8'h00);
        chk("R2 data", nrz_out, 8'h69);
      end
    end
    repeat (8) @(negedge clk);
    chk("R4 hold before user byte", nrz_out, 8'h69);
    // R4: user bytes pass through
    for (int u = 0; u < 6; u++) begin
      send(8'(8'hA0 + 8'(u * 7)));
      chk("R4 user byte", nrz_out, 8'(8'hA0 + 8'(u * 7)));
      repeat (8) @(negedge clk);
      chk("R4 held", nrz_out, 8'(8'hA0 + 8'(u * 7)));
    end
    // R7: marks after detection are plain data
    send(8'h1F);
    chk("R7 lead as data", nrz_out, 8'h1F);
    repeat (20) @(negedge clk);
    chk("R7 no insertion", nrz_out, 8'h1F);
    chk("R7 sync stays low", {7'b0, sync_n}, 8'h00);
    send(8'h69);
    chk("R7 trail as data", nrz_out, 8'h69);

    // R9 / R10: scan mode
    scan_en = 1'b1;
    regate();
    send(8'h69);
    chk("R9 mark ignored", {7'b0, sync_n}, 8'h01);
    send(8'h1F);
    repeat (20) @(negedge clk);
    chk("R9 lead ignored", {7'b0, sync_n}, 8'h01);
    sfc_hit = 1'b1;
    @(posedge clk); @(negedge clk);
    sfc_hit = 1'b0;
    chk("R9 sfc detect", {7'b0, sync_n}, 8'h00);
    chk("R9 sfc data", nrz_out, 8'h00);
    for (int b = 0; b < 256; b += 17) begin
      send(8'(b));
      chk("R10 defect flag", nrz_out, (b != 0) ? 8'h80 : 8'h00);
    end
    send(8'h00);
    chk("R10 clean byte", nrz_out, 8'h00);
    scan_en = 1'b0;
    rd_gate = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R6 final oe", {7'b0, nrz_oe, sync_n}, 8'h01);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule